// File: doc/BRIEF.md
# ADC conversion control and status

This block is the digital control and status logic in front of a successive-approximation converter. It holds one 8-bit control/status register. The register carries a conversion-complete flag, an interrupt enable, a continuous-mode enable and a 5-bit channel number. A simple bus writes the register and reads it back. A separate strobe marks a read of the result low byte, which acknowledges the flag.

The block issues one-cycle start pulses and a channel number to the converter. It tracks whether a conversion is in flight and takes the converter's done and compare-true handshakes. It also drives a level interrupt. Conversions begin either from a register write (software trigger) or from a rising edge on a hardware trigger input (hardware trigger). The `trig_hw_mode` input picks between the two. Channel code 11111 parks the converter and stops any running sequence.

Top module: `adc_ctl_status`

## Requirements
- R1: The register reads as bit 7 = completion flag, bit 6 = interrupt enable, bit 5 = continuous enable, bits 4:0 = channel. A write stores bits 6:0, and bit 7 of the write data has no effect.
- R2: After reset the register reads 0x1F. There is no start pulse, the converter is not busy and the interrupt is low.
- R3: When the converter accepts a done while compare is off, the flag sets. When compare is on, the flag sets only if cmp_true is high with that done. A done arriving while idle is ignored.
- R4: Any register write clears the flag, and a done in the same cycle as a write is discarded. A result-low read clears the flag, but a done that sets the flag in the same cycle as such a read wins.
- R5: The irq output equals the flag AND the interrupt enable, as held in the register.
- R6: In software mode, a write with a channel other than 11111 gives one conv_start pulse in the next cycle and raises conv_busy. With continuous mode off, conv_busy drops in the cycle after done.
- R7: With continuous mode on, every accepted done is followed in the next cycle by a new conv_start on the held channel, and conv_busy stays high.
- R8: In hardware mode, a write never starts a conversion and aborts one in flight. A rising edge of hw_trig while idle gives a conv_start in the next cycle. Edges seen while busy are ignored.
- R9: A write of channel 11111 drops conv_busy in the next cycle, gives no start pulse, and ends continuous mode with no extra conversion. Hardware edges are ignored while this channel is held.
- R10: In software mode, a write during a conversion aborts it and starts a new one on the newly written channel, which appears on conv_chan together with the start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read-back value |
| res_lo_rd | input | 1 | Strobe marking a read of the result low byte |
| trig_hw_mode | input | 1 | 1 = hardware trigger, 0 = software trigger |
| hw_trig | input | 1 | Hardware trigger, synchronous to clk |
| cmp_en | input | 1 | Compare mode on |
| conv_done | input | 1 | Converter finished the current conversion |
| cmp_true | input | 1 | Compare result for the finishing conversion |
| conv_start | output | 1 | One-cycle start request to the converter |
| conv_chan | output | 5 | Channel for the converter |
| conv_busy | output | 1 | Conversion in flight; converter powered |
| irq | output | 1 | Conversion-complete interrupt level |

## Verification
Two pairs of functions can fall in the same cycle. A converter done can meet a result-low read, and a converter done can meet a register write. The bench provokes each pair by waiting until the stub's done is visible ahead of an edge and then raising the read or write strobe for that same edge. It judges the outcome against a behavioural model that sets the flag in the first case, and discards the done and restarts the conversion in the second. Because the model is compared on every clock, the cycles after the collision are also judged.

// File: rtl/adc_ctl_pkg.sv
// Package: shared widths and the register layout for the ADC control block.
// Assumes the register is 8 bits: flag, enable bits, then the channel field.
package adc_ctl_pkg;
    localparam int CHAN_W = 5;
    localparam logic [CHAN_W-1:0] CHAN_OFF = {CHAN_W{1'b1}};

    typedef struct packed {
        logic              flag;
        logic              ie;
        logic              cont;
        logic [CHAN_W-1:0] chan;
    } csr_t;

    localparam int CSR_W = $bits(csr_t);
endpackage

// File: rtl/adc_trig_edge.sv
// Rising-edge detector for the hardware trigger.
// Assumes trig is already synchronous to clk.
module adc_trig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic rise
);
    logic trig_q;

    // Keep last cycle's trigger level.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig;
    end

    assign rise = trig & ~trig_q;
endmodule

// File: rtl/adc_csr_regs.sv
// Control/status register: holds the enables and channel, and owns the
// completion flag and the interrupt level.
// Assumes done_acc is already qualified by the sequencer (busy, no write).
module adc_csr_regs
    import adc_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  csr_t wdata,
    input  logic rd_lo,
    input  logic done_acc,
    input  logic cmp_en,
    input  logic cmp_true,
    output csr_t csr_q,
    output logic irq
);
    logic set_flag;
    logic unused_wr_flag;

    assign unused_wr_flag = wdata.flag;
    assign set_flag = done_acc & (~cmp_en | cmp_true);

    // Register update: write loads fields and clears flag; else set beats read-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_q.flag <= 1'b0;
            csr_q.ie   <= 1'b0;
            csr_q.cont <= 1'b0;
            csr_q.chan <= CHAN_OFF;
        end else if (wr_en) begin
            csr_q.flag <= 1'b0;
            csr_q.ie   <= wdata.ie;
            csr_q.cont <= wdata.cont;
            csr_q.chan <= wdata.chan;
        end else if (set_flag) begin
            csr_q.flag <= 1'b1;
        end else if (rd_lo) begin
            csr_q.flag <= 1'b0;
        end
    end

    assign irq = csr_q.flag & csr_q.ie;

    p_flag_needs_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csr_q.flag) |-> $past(done_acc));
    p_write_clears_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !csr_q.flag);
    p_read_clears_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !done_acc && !wr_en) |=> !csr_q.flag);
endmodule

// File: rtl/adc_conv_seq.sv
// Conversion sequencer: decides when to pulse start, tracks busy, and
// qualifies the converter's done.
// Assumes the converter restarts on any start pulse.
module adc_conv_seq
    import adc_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHAN_W-1:0] wr_chan,
    input  logic              hw_mode,
    input  logic              trig_rise,
    input  logic              conv_done,
    input  logic              cont,
    input  logic [CHAN_W-1:0] chan,
    output logic              start,
    output logic              busy,
    output logic              done_acc
);
    logic start_d, busy_d;

    assign done_acc = busy & conv_done & ~wr_en;

    // Next-state choice: write first, then completion, then hardware edge.
    always_comb begin
        start_d = 1'b0;
        busy_d  = busy;
        if (wr_en) begin
            if (wr_chan == CHAN_OFF || hw_mode) begin
                busy_d = 1'b0;
            end else begin
                start_d = 1'b1;
                busy_d  = 1'b1;
            end
        end else if (done_acc) begin
            if (cont && chan != CHAN_OFF) start_d = 1'b1;
            else                          busy_d  = 1'b0;
        end else if (!busy && hw_mode && trig_rise && chan != CHAN_OFF) begin
            start_d = 1'b1;
            busy_d  = 1'b1;
        end
    end

    // State registers for start pulse and busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start <= 1'b0;
            busy  <= 1'b0;
        end else begin
            start <= start_d;
            busy  <= busy_d;
        end
    end

    p_start_with_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> busy);
    p_single_goes_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_done && !wr_en && !cont) |=> !busy);
    p_cont_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_done && !wr_en && cont && chan != CHAN_OFF) |=> (start && busy));
    p_busy_ignores_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_en && !conv_done) |=> !start);
    p_off_code_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_chan == CHAN_OFF) |=> (!busy && !start));
endmodule

// File: rtl/adc_ctl_status.sv
// Top: ADC control and status. Ties the register, sequencer and trigger
// edge detector together. Assumes all inputs are synchronous to clk.
module adc_ctl_status
    import adc_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [CSR_W-1:0]  reg_wdata,
    output logic [CSR_W-1:0]  reg_rdata,
    input  logic              res_lo_rd,
    input  logic              trig_hw_mode,
    input  logic              hw_trig,
    input  logic              cmp_en,
    input  logic              conv_done,
    input  logic              cmp_true,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic              conv_busy,
    output logic              irq
);
    csr_t csr_q, wdata_s;
    logic trig_rise, done_acc;

    assign wdata_s = csr_t'(reg_wdata);

    adc_trig_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .trig (hw_trig),
        .rise (trig_rise)
    );

    adc_csr_regs u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wdata   (wdata_s),
        .rd_lo   (res_lo_rd),
        .done_acc(done_acc),
        .cmp_en  (cmp_en),
        .cmp_true(cmp_true),
        .csr_q   (csr_q),
        .irq     (irq)
    );

    adc_conv_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wr_chan  (wdata_s.chan),
        .hw_mode  (trig_hw_mode),
        .trig_rise(trig_rise),
        .conv_done(conv_done),
        .cont     (csr_q.cont),
        .chan     (csr_q.chan),
        .start    (conv_start),
        .busy     (conv_busy),
        .done_acc (done_acc)
    );

    assign reg_rdata = csr_q;
    assign conv_chan = csr_q.chan;

    p_start_chan_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (conv_chan != CHAN_OFF));
    p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (reg_rdata[7] && reg_rdata[6]));
endmodule

// File: tb/sim_adc_ctl_status.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module sim_adc_ctl_status;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0, res_lo_rd = 1'b0, trig_hw_mode = 1'b0, hw_trig = 1'b0;
    logic cmp_en = 1'b0, cmp_true = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic conv_done, conv_start, conv_busy, irq;
    logic [4:0] conv_chan;

    int errors = 0, checks = 0, cycles = 0, nstarts = 0, stub_cnt = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_ctl_status u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .res_lo_rd(res_lo_rd), .trig_hw_mode(trig_hw_mode),
        .hw_trig(hw_trig), .cmp_en(cmp_en), .conv_done(conv_done), .cmp_true(cmp_true),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_busy(conv_busy), .irq(irq)
    );

    // Converter stub: done LAT cycles after a sampled start.
    always @(posedge clk) begin
        if (!rst_n)          stub_cnt <= 0;
        else if (conv_start) stub_cnt <= LAT;
        else if (stub_cnt != 0) stub_cnt <= stub_cnt - 1;
        if (rst_n && conv_start) nstarts <= nstarts + 1;
    end
    assign conv_done = (stub_cnt == 1);

    // Reference model state.
    bit m_flag, m_ie, m_cont, m_busy, m_start, m_tprev;
    int m_chan;

    always @(posedge clk) begin
        bit rise, acc, nb, ns;
        if (!rst_n) begin
            m_flag = 0; m_ie = 0; m_cont = 0; m_chan = 31;
            m_busy = 0; m_start = 0; m_tprev = 0;
        end else begin
            rise = hw_trig && !m_tprev;
            m_tprev = hw_trig;
            acc = m_busy && conv_done && !reg_wr;
            nb = m_busy; ns = 0;
            if (reg_wr) begin
                m_ie = reg_wdata[6]; m_cont = reg_wdata[5];
                m_chan = int'(reg_wdata[4:0]); m_flag = 0;
                if (m_chan == 31 || trig_hw_mode) nb = 0;
                else begin ns = 1; nb = 1; end
            end else begin
                if (acc && (!cmp_en || cmp_true)) m_flag = 1;
                else if (res_lo_rd) m_flag = 0;
                if (acc) begin
                    if (m_cont && m_chan != 31) ns = 1; else nb = 0;
                end else if (!m_busy && trig_hw_mode && rise && m_chan != 31) begin
                    ns = 1; nb = 1;
                end
            end
            m_busy = nb; m_start = ns;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        cycles++;
        if (cycles > 1) begin
            check(reg_rdata == {m_flag, m_ie, m_cont, m_chan[4:0]}, "R1 R3 R4 register",
                  int'(reg_rdata), int'({m_flag, m_ie, m_cont, m_chan[4:0]}));
            check(conv_start == m_start, "R6 R7 R8 R10 conv_start", int'(conv_start), int'(m_start));
            check(conv_busy == m_busy, "R6 R8 R9 conv_busy", int'(conv_busy), int'(m_busy));
            check(irq == (m_flag & m_ie), "R5 irq", int'(irq), int'(m_flag & m_ie));
            check(conv_chan == m_chan[4:0], "R10 conv_chan", int'(conv_chan), m_chan);
        end
        if (cycles > 20000 && !finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
            summary();
        end
    end

    task automatic summary();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); reg_wr = 1; reg_wdata = v;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!conv_done) @(negedge clk);
    endtask

    task automatic pulse_trig();
        @(negedge clk); hw_trig = 1;
        @(negedge clk); hw_trig = 0;
    endtask

    initial begin
        int s0;
        idle(3); rst_n = 1;
        @(negedge clk);
        check(reg_rdata == 8'h1F, "R2 reset value", int'(reg_rdata), 'h1F);
        check(!conv_busy && !irq && !conv_start, "R2 reset outputs", int'(conv_busy), 0);

        // Software single conversion; bit 7 write data ignored.
        wr(8'h83);
        check(conv_start == 1 && conv_chan == 3, "R6 start after write", int'(conv_start), 1);
        idle(LAT + 3);
        check(reg_rdata == 8'h83 && !conv_busy, "R1 R3 R6 flag set, idle", int'(reg_rdata), 'h83);
        @(negedge clk); res_lo_rd = 1; @(negedge clk); res_lo_rd = 0;
        check(reg_rdata == 8'h03, "R4 read clears flag", int'(reg_rdata), 'h03);

        // Interrupt level.
        wr(8'h45); idle(LAT + 3);
        check(irq == 1, "R5 irq high", int'(irq), 1);
        wr(8'h05);
        check(irq == 0, "R5 irq low after write", int'(irq), 0);
        idle(LAT + 3);

        // Compare gating.
        cmp_en = 1; cmp_true = 0;
        wr(8'h02); idle(LAT + 3);
        check(reg_rdata[7] == 0 && !conv_busy, "R3 compare false no flag", int'(reg_rdata), 'h02);
        cmp_true = 1;
        wr(8'h02); idle(LAT + 3);
        check(reg_rdata[7] == 1, "R3 compare true flag", int'(reg_rdata), 'h82);
        cmp_en = 0; cmp_true = 0;

        // Continuous.
        s0 = nstarts;
        wr(8'h21); idle(4 * LAT);
        check(nstarts - s0 >= 3 && conv_busy, "R7 continuous restarts", nstarts - s0, 3);
        wr(8'h3F); idle(2);
        s0 = nstarts; idle(3 * LAT);
        check(nstarts == s0 && !conv_busy, "R9 off code stops", nstarts - s0, 0);

        // Abort and restart.
        wr(8'h04); idle(2);
        wr(8'h07);
        check(conv_start == 1 && conv_chan == 7, "R10 restart new channel", int'(conv_chan), 7);
        idle(LAT + 3);

        // Hardware trigger mode.
        trig_hw_mode = 1;
        s0 = nstarts;
        wr(8'h06); idle(3);
        check(nstarts == s0 && !conv_busy, "R8 write no start in hw mode", nstarts - s0, 0);
        pulse_trig();
        check(conv_start == 1, "R8 edge starts", int'(conv_start), 1);
        idle(1); s0 = nstarts;
        pulse_trig(); idle(1);
        check(nstarts == s0, "R8 edge while busy ignored", nstarts - s0, 0);
        idle(LAT + 2);
        s0 = nstarts;
        wr(8'h26); pulse_trig(); idle(4 * LAT);
        check(nstarts - s0 >= 3, "R7 R8 hw continuous", nstarts - s0, 3);
        wr(8'h3F); idle(2);
        s0 = nstarts;
        pulse_trig(); idle(LAT);
        check(nstarts == s0 && !conv_busy, "R9 edge ignored on off code", nstarts - s0, 0);
        trig_hw_mode = 0;

        // Collision: done with result read.
        wr(8'h01); wait_done();
        res_lo_rd = 1; @(negedge clk); res_lo_rd = 0;
        check(reg_rdata[7] == 1, "R4 done beats read", int'(reg_rdata), 'h81);
        // Collision: done with write.
        wr(8'h01); wait_done();
        reg_wr = 1; reg_wdata = 8'h41; @(negedge clk); reg_wr = 0;
        check(reg_rdata == 8'h41 && conv_start, "R4 done with write discarded", int'(reg_rdata), 'h41);
        idle(LAT + 3);

        summary();
    end
endmodule